// File: doc/BRIEF.md
# Interlaced Master Sync and Line Timing Generator

This block produces the raster timing of an interlaced composite video encoder when it is the timing master. From a 27 MHz clock it derives a sample tick at half that rate and counts samples along each line, lines within each field, and fields within the colour sequence. From those counts it drives active-low horizontal and vertical sync, a blanking flag, a colour-burst gate and the current line number in whole-frame numbering. The pixel path and the subcarrier generator downstream use these outputs to insert sync, burst and blanking.

A static input picks 525-line or 625-line operation. A second static input turns the vertical sync output into an odd/even field indicator. A sleep input forces the counters back to the start of vertical sync in the first field, while the four timing flags keep their last values. Two small state machines follow the counters. The line machine has the states LN_IDLE, LN_SYNC, LN_BACK, LN_ACTIVE and LN_FRONT, and moves IDLE→SYNC on the first tick, SYNC→BACK past the sync width, BACK→ACTIVE at the first active sample, ACTIVE→FRONT after the last one, and FRONT→SYNC when the line wraps. The field machine has the states FD_IDLE, FD_VS_FULL, FD_VS_HALF and FD_OPEN. It moves IDLE→VS_FULL on the first line and VS_FULL→OPEN (525) or VS_FULL→VS_HALF (625) after the whole sync lines. It moves VS_HALF→OPEN after line 3 and OPEN→VS_FULL when a new field begins. Sleep returns both machines to IDLE.

Top module: `video_timing_gen`

## Requirements
- R1: `h_count` advances by one on every second rising clock edge and runs 1..L, where L is 858 with `mode625`=0 and 864 with `mode625`=1. After L it returns to 1. After reset or sleep it reads 0, and it becomes 1 on the second rising edge after sleep or reset ends.
- R2: `v_count` advances when `h_count` returns to 1. Fields with an even `field_idx` have 262 lines (525) or 312 lines (625). Fields with an odd index have 263 or 313 lines. After the last line it returns to 1.
- R3: `field_idx` advances when `v_count` wraps. It cycles 0..3 with `mode625`=0 and 0..7 with `mode625`=1. Index 0 is field 1.
- R4: `line_num` equals `v_count` in even-index fields and `v_count`+262 (525) or `v_count`+312 (625) in odd-index fields. It is 0 while `v_count` is 0.
- R5: `hsync_n` is low exactly while `h_count` is in 0..63.
- R6: With `field_flag_sel`=0, `vsync_n` is low while `v_count` is in 0..3 (525). In 625 mode it is low for `v_count` in 0..2 and for `v_count`=3 with `h_count` ≤ L/2, which gives two and a half lines.
- R7: With `field_flag_sel`=1, `vsync_n` is high in odd-numbered fields (even `field_idx`) and low in even-numbered fields.
- R8: `blank` is high unless `h_count` lies in the 720-sample window ending 20 samples before the line end (L−739..L−20).
- R9: `blank` is also high on the vertically blanked lines, by `line_num`. In 525 mode these are 0..9 and 263..272. In 625 mode they are 0..6, 311..318 and 624..625 for `field_idx` with bit 1 = 0, and 0..5, 311..319 and 624..625 for bit 1 = 1.
- R10: `burst_en` is high only for `h_count` in 73..106 (525) or 77..106 (625). In other words, burst begins after 72 or 76 samples and lasts 34 or 30 samples.
- R11: `burst_en` stays low on these lines, by `line_num`. In 525 mode: 0..9 and 264..272. In 625 mode with `field_idx` bit 1 = 0: 0..6, 310..318 and 623..625. With bit 1 = 1: 0..5, 311..319 and 622..625.
- R12: While `sleep` is high, `h_count`, `v_count`, `field_idx` and `line_num` read 0 after the next edge, and `hsync_n`, `vsync_n`, `blank` and `burst_en` hold their values.
- R13: While `rst_n` is low, all counts read 0, `hsync_n`=`vsync_n`=1, `blank`=1 and `burst_en`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 27 MHz clock, twice the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Forces counters to the start of field 1 and holds the flags |
| mode625 | input | 1 | 1 selects 625-line timing, 0 selects 525-line timing |
| field_flag_sel | input | 1 | 1 makes `vsync_n` an odd/even field indicator |
| hsync_n | output | 1 | Active-low horizontal sync |
| vsync_n | output | 1 | Active-low vertical sync or field indicator |
| blank | output | 1 | High outside the active picture |
| burst_en | output | 1 | High during the colour-burst gate |
| h_count | output | HW | Sample position in the line, 1..L |
| v_count | output | 10 | Line within the field, 1-based |
| field_idx | output | 3 | Position in the colour field sequence |
| line_num | output | 10 | Line number in whole-frame numbering |

## Verification
The checker assumes that `mode625` and `field_flag_sel` change only while `sleep` or reset is asserted. It also assumes that the parameters put the burst window after the sync width and before the active window. The bench changes the configuration only inside sleep pulses of random length. It uses shortened line lengths so that full 4-field and 8-field sequences fit in the run, and keeps the burst window between sync and the active window. The line and field tables keep their full standard numbering.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    localparam int FRAME_W = 10;

    // Lines per field: even field index first, odd index second
    localparam logic [FRAME_W-1:0] FA_525 = 10'd262;
    localparam logic [FRAME_W-1:0] FB_525 = 10'd263;
    localparam logic [FRAME_W-1:0] FA_625 = 10'd312;
    localparam logic [FRAME_W-1:0] FB_625 = 10'd313;

    // Whole lines of vertical sync; 625 adds half of line 3
    localparam logic [FRAME_W-1:0] VS_FULL_525 = 10'd3;
    localparam logic [FRAME_W-1:0] VS_FULL_625 = 10'd2;
    localparam logic [FRAME_W-1:0] VS_HALF_LN  = 10'd3;

    typedef enum logic [2:0] {
        LN_IDLE,
        LN_SYNC,
        LN_BACK,
        LN_ACTIVE,
        LN_FRONT
    } line_state_e;

    typedef enum logic [1:0] {
        FD_IDLE,
        FD_VS_FULL,
        FD_VS_HALF,
        FD_OPEN
    } field_state_e;

    function automatic logic in_rng(input logic [FRAME_W-1:0] x, input int lo, input int hi);
        return (int'(x) >= lo) && (int'(x) <= hi);
    endfunction

endpackage

// File: rtl/vtg_hcount.sv
module vtg_hcount
    import vtg_pkg::*;
#(
    parameter int L525     = 858,
    parameter int L625     = 864,
    parameter int HSYNC_W  = 63,
    parameter int FRONT_W  = 20,
    parameter int ACTIVE_W = 720,
    localparam int HW      = $clog2(((L625 > L525) ? L625 : L525) + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep,
    input  logic          mode625,
    output logic [HW-1:0] h_q,
    output logic [HW-1:0] h_nxt,
    output logic          line_start,
    output line_state_e   ln_nxt
);

    logic          phase_q;
    logic          tick;
    logic          wrap;
    logic [HW-1:0] line_len;
    logic [HW-1:0] act_first;
    logic [HW-1:0] act_last;
    line_state_e   ln_q;

    always_comb begin
        line_len  = mode625 ? HW'(L625) : HW'(L525);
        act_first = line_len - HW'(FRONT_W + ACTIVE_W - 1);
        act_last  = line_len - HW'(FRONT_W);
    end

    assign tick       = phase_q & ~sleep;
    assign wrap       = (h_q == '0) || (h_q == line_len);
    assign line_start = tick & wrap;

    always_comb begin
        if (sleep) begin
            h_nxt = '0;
        end else if (tick) begin
            h_nxt = wrap ? HW'(1) : h_q + HW'(1);
        end else begin
            h_nxt = h_q;
        end
    end

    // Line state machine: next state from the next sample position
    always_comb begin
        ln_nxt = ln_q;
        if (sleep) begin
            ln_nxt = LN_IDLE;
        end else begin
            unique case (ln_q)
                LN_IDLE:   if (h_nxt != '0)               ln_nxt = LN_SYNC;
                LN_SYNC:   if (h_nxt > HW'(HSYNC_W))      ln_nxt = LN_BACK;
                LN_BACK:   if (h_nxt >= act_first)        ln_nxt = LN_ACTIVE;
                LN_ACTIVE: if (h_nxt > act_last)          ln_nxt = LN_FRONT;
                LN_FRONT:  if (h_nxt == HW'(1))           ln_nxt = LN_SYNC;
                default:                                  ln_nxt = LN_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            h_q     <= '0;
            ln_q    <= LN_IDLE;
        end else begin
            phase_q <= ~sleep & ~phase_q;
            h_q     <= h_nxt;
            ln_q    <= ln_nxt;
        end
    end

endmodule

// File: rtl/vtg_vcount.sv
module vtg_vcount
    import vtg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep,
    input  logic               mode625,
    input  logic               line_start,
    output logic [FRAME_W-1:0] v_q,
    output logic [FRAME_W-1:0] v_nxt,
    output logic [2:0]         f_q,
    output logic [2:0]         f_nxt,
    output field_state_e       fd_nxt
);

    logic [FRAME_W-1:0] field_len;
    logic [FRAME_W-1:0] full_lines;
    logic [2:0]         last_field;
    logic               field_end;
    field_state_e       fd_q;

    always_comb begin
        if (f_q[0]) begin
            field_len = mode625 ? FB_625 : FB_525;
        end else begin
            field_len = mode625 ? FA_625 : FA_525;
        end
        full_lines = mode625 ? VS_FULL_625 : VS_FULL_525;
        last_field = mode625 ? 3'd7 : 3'd3;
    end

    assign field_end = line_start && (v_q == field_len);

    always_comb begin
        if (sleep) begin
            v_nxt = '0;
            f_nxt = '0;
        end else begin
            v_nxt = v_q;
            f_nxt = f_q;
            if (line_start) begin
                v_nxt = ((v_q == '0) || field_end) ? FRAME_W'(1) : v_q + FRAME_W'(1);
            end
            if (field_end) begin
                f_nxt = (f_q == last_field) ? 3'd0 : f_q + 3'd1;
            end
        end
    end

    // Field state machine: tracks the vertical sync interval
    always_comb begin
        fd_nxt = fd_q;
        if (sleep) begin
            fd_nxt = FD_IDLE;
        end else begin
            unique case (fd_q)
                FD_IDLE:    if (v_nxt != '0) fd_nxt = FD_VS_FULL;
                FD_VS_FULL: if (v_nxt > full_lines) fd_nxt = mode625 ? FD_VS_HALF : FD_OPEN;
                FD_VS_HALF: if (v_nxt > VS_HALF_LN) fd_nxt = FD_OPEN;
                FD_OPEN:    if (v_nxt == FRAME_W'(1)) fd_nxt = FD_VS_FULL;
                default:                            fd_nxt = FD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q  <= '0;
            f_q  <= '0;
            fd_q <= FD_IDLE;
        end else begin
            v_q  <= v_nxt;
            f_q  <= f_nxt;
            fd_q <= fd_nxt;
        end
    end

endmodule

// File: rtl/vtg_decode.sv
module vtg_decode
    import vtg_pkg::*;
#(
    parameter int L525     = 858,
    parameter int L625     = 864,
    parameter int BST_525  = 72,
    parameter int BLEN_525 = 34,
    parameter int BST_625  = 76,
    parameter int BLEN_625 = 30,
    localparam int HW      = $clog2(((L625 > L525) ? L625 : L525) + 1)
) (
    input  logic               mode625,
    input  logic               field_flag_sel,
    input  logic [HW-1:0]      h_nxt,
    input  logic [FRAME_W-1:0] v_nxt,
    input  logic [2:0]         f_nxt,
    input  line_state_e        ln_nxt,
    input  field_state_e       fd_nxt,
    output logic               hsync_n_d,
    output logic               vsync_n_d,
    output logic               blank_d,
    output logic               burst_d,
    output logic [FRAME_W-1:0] line_d
);

    logic [HW-1:0] half_len;
    logic [HW-1:0] b_first;
    logic [HW-1:0] b_last;
    logic          vs_on;
    logic          v_blank;
    logic          b_off;
    logic          grp_b;

    always_comb begin
        half_len = (mode625 ? HW'(L625) : HW'(L525)) >> 1;
        b_first  = mode625 ? HW'(BST_625 + 1) : HW'(BST_525 + 1);
        b_last   = mode625 ? HW'(BST_625 + BLEN_625) : HW'(BST_525 + BLEN_525);
    end

    // Frame line number
    always_comb begin
        if (v_nxt == '0) begin
            line_d = '0;
        end else if (f_nxt[0]) begin
            line_d = v_nxt + (mode625 ? FA_625 : FA_525);
        end else begin
            line_d = v_nxt;
        end
    end

    // Vertical blanking and burst suppression tables
    always_comb begin
        grp_b = f_nxt[1];
        if (!mode625) begin
            v_blank = in_rng(line_d, 0, 9) || in_rng(line_d, 263, 272);
            b_off   = in_rng(line_d, 0, 9) || in_rng(line_d, 264, 272);
        end else if (!grp_b) begin
            v_blank = in_rng(line_d, 0, 6) || in_rng(line_d, 311, 318) || in_rng(line_d, 624, 625);
            b_off   = in_rng(line_d, 0, 6) || in_rng(line_d, 310, 318) || in_rng(line_d, 623, 625);
        end else begin
            v_blank = in_rng(line_d, 0, 5) || in_rng(line_d, 311, 319) || in_rng(line_d, 624, 625);
            b_off   = in_rng(line_d, 0, 5) || in_rng(line_d, 311, 319) || in_rng(line_d, 622, 625);
        end
    end

    always_comb begin
        unique case (fd_nxt)
            FD_IDLE, FD_VS_FULL: vs_on = 1'b1;
            FD_VS_HALF:          vs_on = (h_nxt <= half_len);
            default:             vs_on = 1'b0;
        endcase
    end

    assign hsync_n_d = ~((ln_nxt == LN_IDLE) || (ln_nxt == LN_SYNC));
    assign vsync_n_d = field_flag_sel ? ~f_nxt[0] : ~vs_on;
    assign blank_d   = v_blank || (ln_nxt != LN_ACTIVE);
    assign burst_d   = (ln_nxt == LN_BACK) && (h_nxt >= b_first) && (h_nxt <= b_last) && !b_off;

endmodule

// File: rtl/video_timing_gen.sv
module video_timing_gen
    import vtg_pkg::*;
#(
    parameter int L525     = 858,
    parameter int L625     = 864,
    parameter int HSYNC_W  = 63,
    parameter int FRONT_W  = 20,
    parameter int ACTIVE_W = 720,
    parameter int BST_525  = 72,
    parameter int BLEN_525 = 34,
    parameter int BST_625  = 76,
    parameter int BLEN_625 = 30,
    localparam int HW      = $clog2(((L625 > L525) ? L625 : L525) + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep,
    input  logic               mode625,
    input  logic               field_flag_sel,
    output logic               hsync_n,
    output logic               vsync_n,
    output logic               blank,
    output logic               burst_en,
    output logic [HW-1:0]      h_count,
    output logic [FRAME_W-1:0] v_count,
    output logic [2:0]         field_idx,
    output logic [FRAME_W-1:0] line_num
);

    logic [HW-1:0]      h_nxt;
    logic               line_start;
    line_state_e        ln_nxt;
    logic [FRAME_W-1:0] v_nxt;
    logic [2:0]         f_nxt;
    field_state_e       fd_nxt;
    logic               hsync_n_d;
    logic               vsync_n_d;
    logic               blank_d;
    logic               burst_d;
    logic [FRAME_W-1:0] line_d;

    vtg_hcount #(
        .L525    (L525),
        .L625    (L625),
        .HSYNC_W (HSYNC_W),
        .FRONT_W (FRONT_W),
        .ACTIVE_W(ACTIVE_W)
    ) u_hcount (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep     (sleep),
        .mode625   (mode625),
        .h_q       (h_count),
        .h_nxt     (h_nxt),
        .line_start(line_start),
        .ln_nxt    (ln_nxt)
    );

    vtg_vcount u_vcount (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep     (sleep),
        .mode625   (mode625),
        .line_start(line_start),
        .v_q       (v_count),
        .v_nxt     (v_nxt),
        .f_q       (field_idx),
        .f_nxt     (f_nxt),
        .fd_nxt    (fd_nxt)
    );

    vtg_decode #(
        .L525    (L525),
        .L625    (L625),
        .BST_525 (BST_525),
        .BLEN_525(BLEN_525),
        .BST_625 (BST_625),
        .BLEN_625(BLEN_625)
    ) u_decode (
        .mode625       (mode625),
        .field_flag_sel(field_flag_sel),
        .h_nxt         (h_nxt),
        .v_nxt         (v_nxt),
        .f_nxt         (f_nxt),
        .ln_nxt        (ln_nxt),
        .fd_nxt        (fd_nxt),
        .hsync_n_d     (hsync_n_d),
        .vsync_n_d     (vsync_n_d),
        .blank_d       (blank_d),
        .burst_d       (burst_d),
        .line_d        (line_d)
    );

    // Timing flags: captured from next-state decode, frozen during sleep
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hsync_n  <= 1'b1;
            vsync_n  <= 1'b1;
            blank    <= 1'b1;
            burst_en <= 1'b0;
        end else if (!sleep) begin
            hsync_n  <= hsync_n_d;
            vsync_n  <= vsync_n_d;
            blank    <= blank_d;
            burst_en <= burst_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_num <= '0;
        end else begin
            line_num <= line_d;
        end
    end

endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
    parameter int L525 = 858,
    parameter int L625 = 864,
    localparam int HW  = $clog2(((L625 > L525) ? L625 : L525) + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sleep,
    input logic          mode625,
    input logic          hsync_n,
    input logic          blank,
    input logic          burst_en,
    input logic [HW-1:0] h_count,
    input logic [9:0]    v_count,
    input logic [2:0]    field_idx
);

    AST_H_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n || sleep)
        h_count <= (mode625 ? HW'(L625) : HW'(L525))); // R1

    AST_H_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n || sleep)
        (h_count != $past(h_count)) |=> $stable(h_count)); // R1

    AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n || sleep)
        (h_count != $past(h_count)) |-> ((h_count == $past(h_count) + HW'(1)) || (h_count == HW'(1)))); // R1

    AST_V_AT_LINE_START: assert property (@(posedge clk) disable iff (!rst_n || sleep)
        (v_count != $past(v_count)) |-> (h_count == HW'(1))); // R2

    AST_FIELD_SEQ_525: assert property (@(posedge clk) disable iff (!rst_n || sleep)
        !mode625 |-> (field_idx <= 3'd3)); // R3

    AST_SYNC_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n |-> blank); // R8

    AST_BURST_IN_BACK_PORCH: assert property (@(posedge clk) disable iff (!rst_n)
        burst_en |-> (hsync_n && blank)); // R10

endmodule

bind video_timing_gen vtg_checker #(
    .L525(L525),
    .L625(L625)
) u_vtg_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep    (sleep),
    .mode625  (mode625),
    .hsync_n  (hsync_n),
    .blank    (blank),
    .burst_en (burst_en),
    .h_count  (h_count),
    .v_count  (v_count),
    .field_idx(field_idx)
);

// File: tb/video_timing_gen_bench.sv
module video_timing_gen_bench;

    // Shortened lines so that whole field sequences fit in the run
    localparam int L525 = 16;
    localparam int L625 = 18;
    localparam int HSW  = 3;
    localparam int FPW  = 2;
    localparam int ACTW = 8;
    localparam int BS5  = 3;
    localparam int BL5  = 3;
    localparam int BS6  = 4;
    localparam int BL6  = 3;
    localparam int HW   = $clog2(L625 + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep = 1'b0;
    logic          mode625 = 1'b0;
    logic          fsel = 1'b0;
    logic          hsync_n, vsync_n, blank, burst_en;
    logic [HW-1:0] h_count;
    logic [9:0]    v_count;
    logic [2:0]    field_idx;
    logic [9:0]    line_num;

    video_timing_gen #(
        .L525(L525), .L625(L625), .HSYNC_W(HSW), .FRONT_W(FPW), .ACTIVE_W(ACTW),
        .BST_525(BS5), .BLEN_525(BL5), .BST_625(BS6), .BLEN_625(BL6)
    ) u_video_timing_gen (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .mode625(mode625),
        .field_flag_sel(fsel), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .blank(blank), .burst_en(burst_en), .h_count(h_count),
        .v_count(v_count), .field_idx(field_idx), .line_num(line_num)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // ---------------- expectation functions ----------------
    function automatic int flen_f(input logic md, input int f);
        if (f % 2 == 0) return md ? 312 : 262;
        return md ? 313 : 263;
    endfunction

    function automatic int fline_f(input logic md, input int v, input int f);
        if (v == 0) return 0;
        return v + ((f % 2 == 1) ? (md ? 312 : 262) : 0);
    endfunction

    function automatic bit rng(input int x, input int lo, input int hi);
        return (x >= lo) && (x <= hi);
    endfunction

    function automatic bit vbl_f(input logic md, input int fl, input int f);
        if (!md) return rng(fl, 0, 9) || rng(fl, 263, 272);
        if ((f / 2) % 2 == 0) return rng(fl, 0, 6) || rng(fl, 311, 318) || rng(fl, 624, 625);
        return rng(fl, 0, 5) || rng(fl, 311, 319) || rng(fl, 624, 625);
    endfunction

    function automatic bit boff_f(input logic md, input int fl, input int f);
        if (!md) return rng(fl, 0, 9) || rng(fl, 264, 272);
        if ((f / 2) % 2 == 0) return rng(fl, 0, 6) || rng(fl, 310, 318) || rng(fl, 623, 625);
        return rng(fl, 0, 5) || rng(fl, 311, 319) || rng(fl, 622, 625);
    endfunction

    function automatic bit hact_f(input logic md, input int h);
        int len;
        len = md ? L625 : L525;
        return (h >= len - FPW - ACTW + 1) && (h <= len - FPW);
    endfunction

    function automatic bit bwin_f(input logic md, input int h);
        if (md) return (h > BS6) && (h <= BS6 + BL6);
        return (h > BS5) && (h <= BS5 + BL5);
    endfunction

    function automatic bit vs_low_f(input logic md, input int h, input int v);
        int len;
        len = md ? L625 : L525;
        return (v <= (md ? 2 : 3)) || (md && (v == 3) && (h <= len / 2));
    endfunction

    // ---------------- reference model ----------------
    bit   m_ph = 1'b0;
    int   m_h = 0;
    int   m_v = 0;
    int   m_f = 0;
    bit   m_slept = 1'b0;
    logic e_hs = 1'b1;
    logic e_vs = 1'b1;
    logic e_bl = 1'b1;
    logic e_bu = 1'b0;

    always @(posedge clk or negedge rst_n) begin : model
        int nh, nv, nf, len, fl;
        if (!rst_n) begin
            m_ph <= 1'b0; m_h <= 0; m_v <= 0; m_f <= 0; m_slept <= 1'b0;
            e_hs <= 1'b1; e_vs <= 1'b1; e_bl <= 1'b1; e_bu <= 1'b0;
        end else if (sleep) begin
            m_ph <= 1'b0; m_h <= 0; m_v <= 0; m_f <= 0; m_slept <= 1'b1;
        end else begin
            nh = m_h; nv = m_v; nf = m_f;
            len = mode625 ? L625 : L525;
            if (m_ph) begin
                if (m_h == 0 || m_h == len) begin
                    nh = 1;
                    if (m_v == 0) begin
                        nv = 1;
                    end else if (m_v == flen_f(mode625, m_f)) begin
                        nv = 1;
                        nf = (m_f + 1) % (mode625 ? 8 : 4);
                    end else begin
                        nv = m_v + 1;
                    end
                end else begin
                    nh = m_h + 1;
                end
            end
            fl = fline_f(mode625, nv, nf);
            m_ph <= ~m_ph; m_h <= nh; m_v <= nv; m_f <= nf; m_slept <= 1'b0;
            e_hs <= !(nh <= HSW);
            e_vs <= fsel ? (nf % 2 == 0) : !vs_low_f(mode625, nh, nv);
            e_bl <= vbl_f(mode625, fl, nf) || !hact_f(mode625, nh);
            e_bu <= bwin_f(mode625, nh) && !boff_f(mode625, fl, nf);
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all();
        int fl;
        string tg;
        fl = fline_f(mode625, m_v, m_f);
        if (!rst_n) tg = "R13";
        else if (m_slept) tg = "R12";
        else tg = "";
        chk((tg != "") ? tg : "R1", "h_count", 32'(h_count), 32'(m_h));
        chk((tg != "") ? tg : "R2", "v_count", 32'(v_count), 32'(m_v));
        chk((tg != "") ? tg : "R3", "field_idx", 32'(field_idx), 32'(m_f));
        chk((tg != "") ? tg : "R4", "line_num", 32'(line_num), 32'(fl));
        chk((tg != "") ? tg : "R5", "hsync_n", 32'(hsync_n), 32'(e_hs));
        chk((tg != "") ? tg : (fsel ? "R7" : "R6"), "vsync_n", 32'(vsync_n), 32'(e_vs));
        chk((tg != "") ? tg : (vbl_f(mode625, fl, m_f) ? "R9" : "R8"), "blank", 32'(blank), 32'(e_bl));
        chk((tg != "") ? tg : ((bwin_f(mode625, m_h) && boff_f(mode625, fl, m_f)) ? "R11" : "R10"),
            "burst_en", 32'(burst_en), 32'(e_bu));
    endtask

    always @(negedge clk) begin
        if (!done) check_all();
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic sleep_pulse(input int len);
        sleep = 1'b1;
        step(len);
        sleep = 1'b0;
    endtask

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: actual %0d expected fewer cycles", 195000);
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    initial begin : stim
        int seed;
        seed = $urandom(32'd20240611);
        // R13: reset state observed during the first cycles
        step(3);
        rst_n = 1'b1;
        // random prologue with sleep pulses mid-line (R12)
        for (int i = 0; i < 4; i++) begin
            step(40 + int'($urandom % 400));
            sleep_pulse(1 + int'($urandom % 12));
        end
        // 525-line: four fields and the wrap of the field sequence
        step(2 * 525 * L525 * 2 + 300);
        // switch to 625-line inside sleep
        sleep = 1'b1;
        step(2 + int'($urandom % 5));
        mode625 = 1'b1;
        step(2);
        sleep = 1'b0;
        // 625-line, normal vertical sync: two fields
        step(625 * L625 * 2 + 120);
        // field indicator, selected inside sleep
        sleep = 1'b1;
        step(3);
        fsel = 1'b1;
        step(1 + int'($urandom % 4));
        sleep = 1'b0;
        // 625-line: full eight-field sequence plus its wrap
        step(4 * 625 * L625 * 2 + 300);
        // R13: asynchronous reset mid-run
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(60);
        finish_run();
    end

endmodule